// File: doc/BRIEF.md
# Serial burst transmitter, SPI mode 1

This block sends eight stored 4-bit values one after another as a single SPI burst. It works as a master, drives only the serial clock, the data line and an active-low chip select, and reads the values from an external memory through a small read port. One start pulse sends the whole burst, taking the values in address order. Whatever filled the memory, for example a sort stage, should place the value meant to go out first at address 0.

The serial clock runs near 200 kHz. Its half period, in system clock cycles, is set by the system clock frequency parameter. The bus uses mode 1: the clock rests low, the data line changes as the clock rises, and the receiver samples as it falls. Chip select goes low once before the first bit and stays low across all 32 bits. There is a half-period margin before the first clock edge and after the last one. `busy` covers exactly the time chip select is low. A single-cycle `done` marks the return to idle.

Top module: `spi_burst_tx`

## Requirements
- R1: After reset and while idle, `cs_n` is 1, and `sclk`, `mosi`, `busy` and `done` are all 0.
- R2: A `start` pulse sampled while idle drives `cs_n` low and `busy` high at the very next clock edge.
- R3: With H = CLK_HZ / (2 * SCLK_HZ) system cycles, `cs_n` is low for exactly H cycles before the first rising edge of `sclk`, and every high and every low half of `sclk` inside the burst lasts exactly H cycles.
- R4: Mode 1 timing holds: `sclk` rests low, and while `cs_n` is low, `mosi` changes only in the cycle where `sclk` rises. It is therefore stable at every falling edge.
- R5: The burst carries 8 words of 4 bits each, most significant bit first. Word k is the value at memory address k, for k = 0 to 7. Read data must be valid one cycle after `mem_addr` presents the address.
- R6: `cs_n` falls once and rises once per burst, and it stays low between words. `sclk` is low in the cycle before `cs_n` rises.
- R7: After the last falling edge of `sclk`, `cs_n` stays low for exactly H more cycles, then rises.
- R8: `busy` is high in exactly those cycles where `cs_n` is low.
- R9: `done` is a pulse one cycle wide, given only in the cycle where `cs_n` has just risen, once per burst.
- R10: A `start` pulse that arrives while a burst is running has no effect. The burst still carries exactly 8 words, and no second frame follows.
- R11: While `cs_n` is high, `mosi` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a burst when sampled high while idle |
| mem_addr | output | 3 | Read address for the word memory |
| mem_data | input | 4 | Word read from `mem_addr`, valid one cycle later |
| sclk | output | 1 | Serial clock, rests low |
| mosi | output | 1 | Serial data out, MSB first |
| cs_n | output | 1 | Chip select, active low, one frame per burst |
| busy | output | 1 | High while the frame is open |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
A bit counter that is off by one shows up in the word data captured at the falling edges. It also shows as a frame that closes a full bit early or late, so the fault is visible at `cs_n` no later than the end of the burst. A faulty divider or phase state shows up as a wrong half-period length, and the bench measures every half period. The mismatch is therefore caught at the first wrong edge, within H cycles. A wrong address step shows up as a misplaced word in the first burst whose memory holds distinct values. A sequencer that fails to return to idle shows as `busy` or `cs_n` out of step with each other, or as a missing `done`, within one cycle of the expected end.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_SETUP = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

    // system cycles per serial clock half period, never below one
    function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                                input int unsigned sclk_hz);
        int unsigned h;
        h = clk_hz / (2 * sclk_hz);
        return (h < 1) ? 1 : h;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int unsigned HALF = 312
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = spi_burst_pkg::width_of(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic             adv,
    input  logic [WIDTH-1:0] din,
    output logic             bit_out
);
    logic [WIDTH-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh      <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            bit_out <= din[WIDTH-1];
            sh      <= din << 1;
        end else if (adv) begin
            bit_out <= sh[WIDTH-1];
            sh      <= sh << 1;
        end
    end
endmodule

// File: rtl/spi_burst_seq.sv
module spi_burst_seq
    import spi_burst_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          tick,
    output logic                          run,
    output logic                          load,
    output logic                          adv,
    output logic                          clear,
    output logic [width_of(WORDS)-1:0]    addr,
    output logic                          sclk,
    output logic                          cs_n,
    output logic                          busy,
    output logic                          done
);
    localparam int unsigned BW = width_of(WIDTH);
    localparam int unsigned WW = width_of(WORDS);

    tx_state_e       state;
    logic [BW-1:0]   bit_idx;
    logic [WW-1:0]   word_idx;
    logic            word_end;
    logic            last_bit;
    logic            low_end;
    logic            rise_evt;
    logic            next_first;

    assign word_end   = (bit_idx == BW'(WIDTH - 1));
    assign last_bit   = word_end && (word_idx == WW'(WORDS - 1));
    assign low_end    = tick && (state == TX_SHIFT) && !sclk;
    assign rise_evt   = (tick && state == TX_SETUP) || (low_end && !last_bit);
    assign next_first = (state == TX_SETUP) || word_end;
    assign load       = rise_evt && next_first;
    assign adv        = rise_evt && !next_first;
    assign clear      = low_end && last_bit;
    assign run        = (state != TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= TX_IDLE;
            bit_idx  <= '0;
            word_idx <= '0;
            addr     <= '0;
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load)
                addr <= addr + 1'b1;
            unique case (state)
                TX_IDLE: begin
                    if (start) begin
                        state    <= TX_SETUP;
                        cs_n     <= 1'b0;
                        busy     <= 1'b1;
                        bit_idx  <= '0;
                        word_idx <= '0;
                    end
                end
                TX_SETUP: begin
                    if (tick) begin
                        state <= TX_SHIFT;
                        sclk  <= 1'b1;
                    end
                end
                TX_SHIFT: begin
                    if (tick && sclk) begin
                        sclk <= 1'b0;
                    end else if (low_end) begin
                        if (last_bit) begin
                            state <= TX_IDLE;
                            cs_n  <= 1'b1;
                            busy  <= 1'b0;
                            done  <= 1'b1;
                            addr  <= '0;
                        end else begin
                            sclk <= 1'b1;
                            if (word_end) begin
                                bit_idx  <= '0;
                                word_idx <= word_idx + 1'b1;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_burst_tx.sv
module spi_burst_tx
    import spi_burst_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned SCLK_HZ = 200_000,
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned WORDS   = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    output logic [width_of(WORDS)-1:0] mem_addr,
    input  logic [WIDTH-1:0]           mem_data,
    output logic                       sclk,
    output logic                       mosi,
    output logic                       cs_n,
    output logic                       busy,
    output logic                       done
);
    localparam int unsigned HALF = half_cycles(CLK_HZ, SCLK_HZ);

    logic run, tick, load, adv, clear;

    spi_half_timer #(.HALF(HALF)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    spi_burst_seq #(.WIDTH(WIDTH), .WORDS(WORDS)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tick  (tick),
        .run   (run),
        .load  (load),
        .adv   (adv),
        .clear (clear),
        .addr  (mem_addr),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .busy  (busy),
        .done  (done)
    );

    spi_word_shifter #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .load    (load),
        .adv     (adv),
        .din     (mem_data),
        .bit_out (mosi)
    );
endmodule

// File: rtl/spi_burst_tx_chk.sv
module spi_burst_tx_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic busy,
    input logic done
);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (!sclk && !mosi));

    p_busy_frame_r8: assert property (@(posedge clk) disable iff (rst)
        busy == !cs_n);

    p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (!cs_n && busy));

    p_done_at_close_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(!cs_n)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_mosi_mode1_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$rose(sclk)) |-> $stable(mosi));

    p_clock_parked_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> $past(!sclk));
endmodule

bind spi_burst_tx spi_burst_tx_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n),
    .busy  (busy),
    .done  (done)
);

// File: tb/spi_burst_tx_test.sv
module spi_burst_tx_test;
    localparam int unsigned CLK_HZ  = 2_000_000;
    localparam int unsigned SCLK_HZ = 200_000;
    localparam int H = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [2:0] mem_addr;
    logic [3:0] mem_data;
    logic       sclk, mosi, cs_n, busy, done;
    logic [3:0] mem [8];

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) mem_data <= mem[mem_addr];

    spi_burst_tx #(.CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ)) uut (
        .clk(clk), .rst(rst), .start(start), .mem_addr(mem_addr),
        .mem_data(mem_data), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .busy(busy), .done(done)
    );

    // passive receiver and timing monitor
    logic        p_sc = 1'b0, p_cs = 1'b1, p_mosi = 1'b0, first = 1'b0;
    int          seg = 0, setup_len = 0, hold_len = 0;
    int          nbits = 0, cs_falls = 0, cs_rises = 0, done_cnt = 0;
    int          hi_bad = 0, lo_bad = 0, idle_bad = 0, busy_bad = 0, done_bad = 0, mosi_bad = 0;
    logic [31:0] rx = '0;

    task automatic mon_clear();
        nbits = 0; cs_falls = 0; cs_rises = 0; done_cnt = 0; setup_len = 0; hold_len = 0;
        hi_bad = 0; lo_bad = 0; idle_bad = 0; busy_bad = 0; done_bad = 0; mosi_bad = 0;
        rx = '0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (cs_n && (sclk || mosi)) idle_bad++;
            if (busy != !cs_n) busy_bad++;
            if (done) begin
                done_cnt++;
                if (!(cs_n && !p_cs)) done_bad++;
            end
            if (p_cs && !cs_n) begin
                cs_falls++; seg = 1; first = 1'b1;
            end else if (!cs_n) begin
                if (mosi != p_mosi && !(sclk && !p_sc)) mosi_bad++;
                if (sclk != p_sc) begin
                    if (sclk) begin
                        if (first) setup_len = seg;
                        else if (seg != H) lo_bad++;
                        first = 1'b0;
                    end else begin
                        if (seg != H) hi_bad++;
                        rx = {rx[30:0], mosi};
                        nbits++;
                    end
                    seg = 1;
                end else begin
                    seg++;
                end
            end else if (!p_cs && cs_n) begin
                cs_rises++; hold_len = seg;
            end
        end
        p_sc = sclk; p_cs = cs_n; p_mosi = mosi;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] pat);
        for (int i = 0; i < 8; i++) mem[i] = pat[31 - 4*i -: 4];
    endtask

    task automatic pulse_start(input bit expect_open);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (expect_open)
            chk(!cs_n && busy, "R2", "frame open after start", {cs_n, busy}, 2'b01);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_burst(input logic [31:0] pat);
        chk(rx == pat && nbits == 32, "R5", "received words", rx, pat);
        chk(setup_len == H, "R3", "setup cycles", setup_len, H);
        chk(hi_bad == 0 && lo_bad == 0, "R3", "half period errors", hi_bad + lo_bad, 0);
        chk(mosi_bad == 0, "R4", "mosi moved off rising edge", mosi_bad, 0);
        chk(cs_falls == 1 && cs_rises == 1, "R6", "frames", cs_falls * 16 + cs_rises, 8'h11);
        chk(hold_len == H, "R7", "hold cycles", hold_len, H);
        chk(busy_bad == 0, "R8", "busy mismatches", busy_bad, 0);
        chk(done_cnt == 1 && done_bad == 0, "R9", "done pulses", done_cnt * 16 + done_bad, 8'h10);
        chk(idle_bad == 0, "R11", "idle line activity", idle_bad, 0);
    endtask

    task automatic test_reset();
        chk(cs_n && !sclk && !mosi && !busy && !done, "R1", "reset outputs",
            {cs_n, sclk, mosi, busy, done}, 5'b10000);
    endtask

    task automatic test_burst(input logic [31:0] pat);
        fill(pat);
        mon_clear();
        pulse_start(1'b1);
        wait_done();
        check_burst(pat);
    endtask

    task automatic test_start_ignored();
        logic [31:0] pat = 32'h9C3E_7105;
        fill(pat);
        mon_clear();
        pulse_start(1'b1);
        repeat (60) @(negedge clk);
        pulse_start(1'b0);
        wait_done();
        repeat (20) @(negedge clk);
        chk(cs_n && !busy && cs_falls == 1, "R10", "no extra frame", cs_falls, 1);
        check_burst(pat);
    endtask

    task automatic test_back_to_back();
        logic [31:0] pat = 32'h0123_4567;
        fill(pat);
        mon_clear();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        pat = 32'hFEDC_BA98;
        fill(pat);
        @(negedge clk);
        mon_clear();
        pulse_start(1'b1);
        wait_done();
        check_burst(pat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        fill(32'h0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_burst(32'hEDCB_A987);
        test_burst(32'hF0A5_5AF0);
        test_burst(32'hFFFF_FFFF);
        test_start_ignored();
        test_back_to_back();
        test_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule